// File: doc/BRIEF.md
# Timer Clock-Enable Prescaler

This block supplies the count-enable pulses for a group of microcontroller timers. It does not generate clocks. Every output is a one-cycle enable in the system clock domain. One 8-bit control register selects a shared prescaled tick. The choices are the system clock divided by 12, 4 or 48, or an external pin clock divided by 8. The external pin is synchronized before its rising edges are counted. Per-timer bypass bits can replace the prescaled tick with an enable on every system clock cycle.

Timer 0 and timer 1 take either the shared tick or the full rate. When a timer counts external events, its bypass bit is ignored and its enable output is held low. Timer 2 has two halves, a low byte and a high byte, and these can run as two separate 8-bit timers in split mode. Timer 2 does not use the shared tick. Its alternate source is picked by its own select input: the system clock divided by 12, or the synchronized external clock divided by 8. Its bypass bits choose between that source and the full rate. The high-byte bypass bit acts only in split mode. Outside split mode the high-byte enable follows the low-byte enable.

Top module: `tmr_tick_gen`

## Requirements
- R1: After reset the control register reads 0x00, and the shared prescaler runs at the system clock divided by 12.
- R2: A write stores `wr_data[5:0]`, and the stored value is visible on `rd_data` on the next cycle. Bits 7:6 of `rd_data` always read 0, whatever value was written to them.
- R3: Control bits [1:0] select the shared tick from the system clock: 00 gives ÷12, 01 gives ÷4 and 10 gives ÷48. In each case the tick is one cycle long and comes once per period.
- R4: With control bits [1:0] = 11, the external pin passes through a two-flop synchronizer and a rising-edge detector. Every eighth detected edge produces one shared tick, and no tick occurs in a cycle without a detected edge.
- R5: Any register write restarts the shared divider from zero. In a system-clock mode, the first tick then comes one full new period after the write edge.
- R6: Timer 0 uses bit 2 and timer 1 uses bit 3. A 0 gives that timer's enable from the shared tick, and a 1 gives an enable on every cycle. While a timer's counter-select input is 1, its enable is 0 and its bit has no effect.
- R7: Bit 4 = 1 gives the timer 2 low-byte enable on every cycle. Bit 4 = 0 gives it the timer 2 alternate tick: the system clock ÷12 when `t2_alt_sel` is 0, or the synchronized external clock ÷8 when it is 1.
- R8: In split mode, bit 5 selects the high-byte source with the same meaning as bit 4. With split mode off, the high-byte enable equals the low-byte enable, and bit 5 has no effect.
- R9: Every prescaled enable is a single-cycle pulse and never stays high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| ext_clk_in | input | 1 | Asynchronous external clock pin |
| t0_ct_sel | input | 1 | Timer 0 counts external events |
| t1_ct_sel | input | 1 | Timer 1 counts external events |
| t2_alt_sel | input | 1 | Timer 2 alternate source: 0 = sysclk ÷12, 1 = external ÷8 |
| t2_split | input | 1 | Timer 2 runs as two 8-bit halves |
| t0_en | output | 1 | Timer 0 count enable |
| t1_en | output | 1 | Timer 1 count enable |
| t2l_en | output | 1 | Timer 2 low-byte count enable |
| t2h_en | output | 1 | Timer 2 high-byte count enable |

## Verification
The assertions assume that every input except `ext_clk_in` is synchronous to `clk`. They also assume that the external pin holds each level for at least two system clock cycles, so the synchronizer loses no edge. The stimulus changes all synchronous inputs on the falling clock edge. It drives the external pin from a generator whose half-period is three or more cycles, or holds the pin steady. Mode inputs and bypass bits are switched at arbitrary points inside a divider period, so both the restart rule and the hand-over between sources are exercised.

// File: rtl/tmr_tick_pkg.sv
package tmr_tick_pkg;

    typedef enum logic [1:0] {
        PS_DIV_A = 2'b00,
        PS_DIV_B = 2'b01,
        PS_DIV_C = 2'b10,
        PS_EXT   = 2'b11
    } presc_sel_e;

    typedef struct packed {
        logic       t2h_sys;
        logic       t2l_sys;
        logic       t1_sys;
        logic       t0_sys;
        presc_sel_e presc;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int REG_W  = 8;

endpackage

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.chain[CHAIN_W-2] & ~st_q.chain[CHAIN_W-1];

    assert_edge_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/tmr_presc_div.sv
module tmr_presc_div
    import tmr_tick_pkg::*;
#(
    parameter int DIV_A   = 12,
    parameter int DIV_B   = 4,
    parameter int DIV_C   = 48,
    parameter int EXT_DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  presc_sel_e sel_i,
    input  logic       ext_rise_i,
    output logic       tick_o
);
    localparam int MAX_AB = (DIV_A > DIV_B) ? DIV_A : DIV_B;
    localparam int MAX_CE = (DIV_C > EXT_DIV) ? DIV_C : EXT_DIV;
    localparam int MAX_D  = (MAX_AB > MAX_CE) ? MAX_AB : MAX_CE;
    localparam int CNT_W  = $clog2(MAX_D + 1);

    localparam logic [CNT_W-1:0] LIM_A = CNT_W'(DIV_A - 1);
    localparam logic [CNT_W-1:0] LIM_B = CNT_W'(DIV_B - 1);
    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(DIV_C - 1);
    localparam logic [CNT_W-1:0] LIM_E = CNT_W'(EXT_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] lim;
    logic             step;

    always_comb begin
        unique case (sel_i)
            PS_DIV_A: lim = LIM_A;
            PS_DIV_B: lim = LIM_B;
            PS_DIV_C: lim = LIM_C;
            default:  lim = LIM_E;
        endcase
        step = (sel_i == PS_EXT) ? ext_rise_i : 1'b1;

        st_d      = st_q;
        st_d.tick = 1'b0;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (step) begin
            if (st_q.cnt >= lim) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    assert_tick_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    assert_restart_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !tick_o);

    assert_ext_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == PS_EXT && !ext_rise_i) |=> !tick_o);

endmodule

// File: rtl/tmr_en_mux.sv
module tmr_en_mux
    import tmr_tick_pkg::*;
(
    input  ctrl_t ctrl_i,
    input  logic  t0_ct_i,
    input  logic  t1_ct_i,
    input  logic  split_i,
    input  logic  presc_tick_i,
    input  logic  t2_tick_i,
    output logic  t0_en_o,
    output logic  t1_en_o,
    output logic  t2l_en_o,
    output logic  t2h_en_o
);
    logic t2h_split;

    always_comb begin
        t0_en_o   = !t0_ct_i && (ctrl_i.t0_sys || presc_tick_i);
        t1_en_o   = !t1_ct_i && (ctrl_i.t1_sys || presc_tick_i);
        t2l_en_o  = ctrl_i.t2l_sys || t2_tick_i;
        t2h_split = ctrl_i.t2h_sys || t2_tick_i;
        t2h_en_o  = split_i ? t2h_split : t2l_en_o;
    end

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import tmr_tick_pkg::*;
#(
    parameter int DIV_A       = 12,
    parameter int DIV_B       = 4,
    parameter int DIV_C       = 48,
    parameter int EXT_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ext_clk_in,
    input  logic             t0_ct_sel,
    input  logic             t1_ct_sel,
    input  logic             t2_alt_sel,
    input  logic             t2_split,
    output logic             t0_en,
    output logic             t1_en,
    output logic             t2l_en,
    output logic             t2h_en
);
    localparam int N_DIV  = 2;
    localparam int RSVD_W = REG_W - CTRL_W;

    typedef struct packed {
        ctrl_t ctrl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = {{RSVD_W{1'b0}}, st_q.ctrl};

    logic ext_rise;

    tmr_ext_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_clk_in),
        .rise_o (ext_rise)
    );

    presc_sel_e      div_sel [N_DIV];
    logic [N_DIV-1:0] div_clr;
    logic [N_DIV-1:0] div_tick;

    assign div_sel[0] = st_q.ctrl.presc;
    assign div_clr[0] = wr_en;
    assign div_sel[1] = t2_alt_sel ? PS_EXT : PS_DIV_A;
    assign div_clr[1] = 1'b0;

    for (genvar g = 0; g < N_DIV; g++) begin : g_div
        tmr_presc_div #(
            .DIV_A   (DIV_A),
            .DIV_B   (DIV_B),
            .DIV_C   (DIV_C),
            .EXT_DIV (EXT_DIV)
        ) u_div (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr_i      (div_clr[g]),
            .sel_i      (div_sel[g]),
            .ext_rise_i (ext_rise),
            .tick_o     (div_tick[g])
        );
    end

    tmr_en_mux u_mux (
        .ctrl_i       (st_q.ctrl),
        .t0_ct_i      (t0_ct_sel),
        .t1_ct_i      (t1_ct_sel),
        .split_i      (t2_split),
        .presc_tick_i (div_tick[0]),
        .t2_tick_i    (div_tick[1]),
        .t0_en_o      (t0_en),
        .t1_en_o      (t1_en),
        .t2l_en_o     (t2l_en),
        .t2h_en_o     (t2h_en)
    );

    assert_wr_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == {{RSVD_W{1'b0}}, $past(wr_data[CTRL_W-1:0])});

    assert_ct_blocks_t0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        t0_ct_sel |-> !t0_en);

    assert_ct_blocks_t1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        t1_ct_sel |-> !t1_en);

    assert_high_follows_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !t2_split |-> (t2h_en == t2l_en));

    assert_t2_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] |-> t2l_en);

endmodule

// File: tb/tmr_tick_gen_tb.sv
module tmr_tick_gen_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ext_clk_in = 1'b0;
    logic       t0_ct_sel = 1'b0, t1_ct_sel = 1'b0;
    logic       t2_alt_sel = 1'b0, t2_split = 1'b0;
    logic       t0_en, t1_en, t2l_en, t2h_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_tick_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ext_clk_in(ext_clk_in),
        .t0_ct_sel(t0_ct_sel), .t1_ct_sel(t1_ct_sel),
        .t2_alt_sel(t2_alt_sel), .t2_split(t2_split),
        .t0_en(t0_en), .t1_en(t1_en), .t2l_en(t2l_en), .t2h_en(t2h_en)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // external pin generator: half period in cycles, 0 = hold
    int ext_half = 0;
    int ext_cnt  = 0;
    always @(negedge clk) begin
        if (ext_half > 0) begin
            ext_cnt = ext_cnt + 1;
            if (ext_cnt >= ext_half) begin
                ext_cnt = 0;
                ext_clk_in = ~ext_clk_in;
            end
        end
    end

    // behavioural reference model
    int m_reg;
    int m_pin_hist[$];
    int m_cnt[2];
    int m_tick[2];

    function automatic int period_of(int code);
        case (code)
            0: return 12;
            1: return 4;
            2: return 48;
            default: return 8;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg = 0;
            m_pin_hist = '{0, 0, 0};
            m_cnt = '{0, 0};
            m_tick = '{0, 0};
        end else begin
            int rise;
            int code[2];
            int clr[2];
            rise = (m_pin_hist[1] == 1 && m_pin_hist[2] == 0) ? 1 : 0;
            code[0] = m_reg & 3;
            code[1] = t2_alt_sel ? 3 : 0;
            clr[0]  = wr_en ? 1 : 0;
            clr[1]  = 0;
            for (int i = 0; i < 2; i++) begin
                m_tick[i] = 0;
                if (clr[i] != 0) m_cnt[i] = 0;
                else if (code[i] != 3 || rise != 0) begin
                    if (m_cnt[i] >= period_of(code[i]) - 1) begin
                        m_cnt[i] = 0;
                        m_tick[i] = 1;
                    end else m_cnt[i] = m_cnt[i] + 1;
                end
            end
            if (wr_en) m_reg = int'(wr_data) & 8'h3F;
            m_pin_hist.push_front(int'(ext_clk_in));
            void'(m_pin_hist.pop_back());
        end
    end

    task automatic cmp(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        int e_t0, e_t1, e_t2l, e_t2h;
        e_t0  = t0_ct_sel ? 0 : (((m_reg >> 2) & 1) != 0 ? 1 : m_tick[0]);
        e_t1  = t1_ct_sel ? 0 : (((m_reg >> 3) & 1) != 0 ? 1 : m_tick[0]);
        e_t2l = ((m_reg >> 4) & 1) != 0 ? 1 : m_tick[1];
        e_t2h = t2_split ? (((m_reg >> 5) & 1) != 0 ? 1 : m_tick[1]) : e_t2l;
        cmp("R2 rd_data", int'(rd_data), m_reg);
        cmp("R6 t0_en (R3/R4/R5/R9 shared tick)", int'(t0_en), e_t0);
        cmp("R6 t1_en (R3/R4/R5/R9 shared tick)", int'(t1_en), e_t1);
        cmp("R7 t2l_en", int'(t2l_en), e_t2l);
        cmp("R8 t2h_en", int'(t2h_en), e_t2h);
    endtask

    task automatic run(int n);
        repeat (n) begin
            @(negedge clk);
            check_all();
        end
    endtask

    task automatic write_reg(logic [7:0] v);
        wr_en = 1'b1;
        wr_data = v;
        run(1);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        cmp("R1 rd_data after reset", int'(rd_data), 0);
        cmp("R1 t0_en after reset", int'(t0_en), 0);
        run(40);                       // R1 default ÷12
        write_reg(8'h01); run(30);     // R3 ÷4, R5 restart
        write_reg(8'h02); run(110);    // R3 ÷48
        write_reg(8'h02); run(20);     // R5 rewrite mid-count
        write_reg(8'h00); run(30);
        write_reg(8'hC1);              // R2 reserved bits
        cmp("R2 reserved bits read 0", int'(rd_data[7:6]), 0);
        run(10);
        ext_half = 3;
        write_reg(8'h03); run(200);    // R4 external ÷8
        ext_half = 0; run(30);         // R4 no edges, no ticks
        ext_half = 4; run(100);
        write_reg(8'h0D); run(30);     // R6 bypass bits
        t0_ct_sel = 1'b1; run(20);     // R6 counter mode blocks
        write_reg(8'h00); t1_ct_sel = 1'b1; run(30);
        t0_ct_sel = 1'b0; t1_ct_sel = 1'b0;
        t2_alt_sel = 1'b1; run(150);   // R7 alt ext ÷8
        t2_alt_sel = 1'b0; run(40);    // R7 alt ÷12
        write_reg(8'h10); run(20);     // R7 bypass
        write_reg(8'h20); run(30);     // R8 bit5 ignored when not split
        t2_split = 1'b1; run(30);      // R8 split, high bypass
        write_reg(8'h10); run(30);
        t2_alt_sel = 1'b1; run(100);
        write_reg(8'h3F); run(20);
        rst_n = 1'b0; run(1); rst_n = 1'b1;
        run(5);
        cmp("R1 rd_data after second reset", int'(rd_data), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule